// File: doc/BRIEF.md
# External Interrupt Detector

This block watches a set of external interrupt pins (four by default) and turns activity on each one into a sticky pending flag. Each flag drives its own interrupt request output. Every pin passes through a two-flop synchroniser and a one-clock history flop, so any activity on a pin is seen with a fixed latency.

Each channel has two configuration bits. The sense bit selects edge or level sensitivity. The polarity bit selects which edge or which level counts as active. Software reads and writes the sense, polarity and pending registers over a simple single-cycle register port. A pending flag is cleared by writing 1 to it, so software can read the pending register and write the same value back to clear exactly the flags it saw. In level mode the flag is set again on every clock while the pin stays at its active level, so a clear write has no lasting effect until the pin goes inactive.

Changing a channel's sense or polarity bit clears that channel's flag. This stops the reconfiguration from leaving a stale request behind.

Each channel is a two-state machine:
- `CH_IDLE` means no request is pending, and the channel's request output is low. It moves to `CH_PENDING` on a detected event, unless the channel's configuration is being changed in that cycle.
- `CH_PENDING` means a request is pending, and the channel's request output is high. It returns to `CH_IDLE` in either of two cases:
  - a write changes the channel's sense or polarity bit;
  - a 1 is written to the channel's pending bit in a cycle with no new event.

  Otherwise it stays in `CH_PENDING`.

Top module: `eint_detector`

## Requirements
- R1: After reset, the sense, polarity and pending registers read 0 and all request outputs are low. The pin synchronisers reset to the idle-high value, so pins held high cause no request.
- R2: A pin change driven before rising clock edge k is first reflected in the pending flag after edge k+2 and not before, because of two synchroniser stages and one history stage.
- R3: The register address selects the register: 0 = sense, 1 = polarity, 2 = pending, 3 = reads as zero. Bit i of each register belongs to channel i. Reads are combinational and return the stored values. Sense and polarity writes take effect at the next clock edge.
- R4: With sense = 1 (edge) and polarity = 0, a falling edge sets the flag and a rising edge does not.
- R5: With sense = 1 (edge) and polarity = 1, a rising edge sets the flag and a falling edge does not.
- R6: With sense = 0 (level), the flag is set while the synchronised pin is low (polarity 0) or high (polarity 1). It stays set after the pin returns to inactive.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. Writing back a value read from the pending register clears exactly those flags. With no write, a set flag stays set.
- R8: In level mode, a clear write while the pin is still active leaves the flag set. After the pin becomes inactive, the same write clears it.
- R9: A sense or polarity write clears the flag of every channel whose bit the write changes, and suppresses that channel's event in the same cycle. Channels whose bits do not change keep their flags.
- R10: When a channel's event and a clear write to its pending bit land on the same clock edge, the flag stays set.
- R11: Request output i equals pending bit i at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_CH | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 sense, 1 polarity, 2 pending |
| reg_wdata | input | NUM_CH | Write data, one bit per channel |
| reg_rdata | output | NUM_CH | Combinational read data for reg_addr |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
Timing of each result:
- A pin change driven just after a rising edge is first visible on `irq` after the third following rising edge.
- A register write driven after an edge takes effect at the next edge.
- Read data follows `reg_addr` combinationally.

The bench drives every input one time unit after a rising edge. A behavioural model keeps a queue of pin values sampled at each edge and takes the event inputs from the entries two and three edges old. The model's flags, and the read data they imply, are compared with `irq` and `reg_rdata` at every falling edge. The directed checks count edges explicitly after each stimulus. This includes the case where an event and a clear write are timed to meet on the same edge.

// File: rtl/eint_pkg.sv
package eint_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_SENSE = 2'd0,
        SEL_POL   = 2'd1,
        SEL_PEND  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_t;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_PENDING = 1'b1
    } ch_state_t;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int   W       = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_BIT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] sync_old
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                chain[s] <= {W{RST_BIT}};
            end
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < DEPTH; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    // Last synchroniser stage and the one-clock history behind it.
    assign sync_q   = chain[STAGES-1];
    assign sync_old = chain[STAGES];

endmodule

// File: rtl/eint_detect.sv
module eint_detect (
    input  logic sense_edge,
    input  logic pol_high,
    input  logic cur,
    input  logic old,
    output logic hit
);
    logic rise, fall, level_on;

    always_comb begin
        rise     = cur & ~old;
        fall     = ~cur & old;
        level_on = (cur == pol_high);
        if (sense_edge) begin
            hit = pol_high ? rise : fall;
        end else begin
            hit = level_on;
        end
    end

endmodule

// File: rtl/eint_channel.sv
module eint_channel
    import eint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic cfg_chg,
    input  logic clr_req,
    output logic pending
);
    ch_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (!cfg_chg && hit) begin
                    state_d = CH_PENDING;
                end
            end
            CH_PENDING: begin
                if (cfg_chg) begin
                    state_d = CH_IDLE;
                end else if (hit) begin
                    state_d = CH_PENDING;
                end else if (clr_req) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pending = (state_q == CH_PENDING);
    end

endmodule

// File: rtl/eint_detector.sv
module eint_detector
    import eint_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     pin_in,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [NUM_CH-1:0]     reg_wdata,
    output logic [NUM_CH-1:0]     reg_rdata,
    output logic [NUM_CH-1:0]     irq
);
    logic [NUM_CH-1:0] mode_q, pol_q;
    logic [NUM_CH-1:0] pin_sync, pin_old;
    logic [NUM_CH-1:0] hit, cfg_chg, clr_req, pend;
    reg_sel_t          sel;

    assign sel = reg_sel_t'(reg_addr);

    eint_sync #(
        .W       (NUM_CH),
        .STAGES  (SYNC_STAGES),
        .RST_BIT (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_q   (pin_sync),
        .sync_old (pin_old)
    );

    // Write decode: configuration changes per channel and clear requests.
    always_comb begin
        cfg_chg = '0;
        clr_req = '0;
        if (reg_wr) begin
            unique case (sel)
                SEL_SENSE: cfg_chg = reg_wdata ^ mode_q;
                SEL_POL:   cfg_chg = reg_wdata ^ pol_q;
                SEL_PEND:  clr_req = reg_wdata;
                SEL_NONE:  ;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            pol_q  <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_SENSE) mode_q <= reg_wdata;
            if (sel == SEL_POL)   pol_q  <= reg_wdata;
        end
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            eint_detect u_det (
                .sense_edge (mode_q[i]),
                .pol_high   (pol_q[i]),
                .cur        (pin_sync[i]),
                .old        (pin_old[i]),
                .hit        (hit[i])
            );
            eint_channel u_fsm (
                .clk     (clk),
                .rst_n   (rst_n),
                .hit     (hit[i]),
                .cfg_chg (cfg_chg[i]),
                .clr_req (clr_req[i]),
                .pending (pend[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_SENSE: reg_rdata = mode_q;
            SEL_POL:   reg_rdata = pol_q;
            SEL_PEND:  reg_rdata = pend;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = pend;

endmodule

// File: rtl/eint_detector_chk.sv
module eint_detector_chk
    import eint_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [NUM_CH-1:0]     reg_wdata,
    input logic [NUM_CH-1:0]     reg_rdata,
    input logic [NUM_CH-1:0]     irq,
    input logic [NUM_CH-1:0]     mode_q,
    input logic [NUM_CH-1:0]     pol_q,
    input logic [NUM_CH-1:0]     pin_sync
);
    logic [NUM_CH-1:0] lvl_act;
    logic              cfg_wr;

    assign lvl_act = ~mode_q & ~(pin_sync ^ pol_q);
    assign cfg_wr  = reg_wr && (reg_addr == SEL_SENSE || reg_addr == SEL_POL);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (irq == '0));

    p_pend_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == SEL_PEND) |-> (reg_rdata == irq));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((irq & $past(irq)) == $past(irq)));

    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ((irq & $past(lvl_act)) == $past(lvl_act)));

    p_sense_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_SENSE)
        |=> ((irq & ($past(reg_wdata) ^ $past(mode_q))) == '0));

    p_pol_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_POL)
        |=> ((irq & ($past(reg_wdata) ^ $past(pol_q))) == '0));

endmodule

bind eint_detector eint_detector_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .mode_q    (mode_q),
    .pol_q     (pol_q),
    .pin_sync  (pin_sync)
);

// File: tb/eint_detector_tb.sv
module eint_detector_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_in = 4'hF;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_wdata = 4'h0;
    logic [3:0] reg_rdata, irq;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    // Behavioural reference state.
    logic [3:0] m_mode, m_pol, m_flag;
    logic [3:0] hist[$];

    eint_detector u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = '0; m_pol = '0; m_flag = '0;
            hist = '{4'hF, 4'hF, 4'hF};
        end else begin
            logic [3:0] s, p, chg, nf;
            s = hist[1];
            p = hist[2];
            chg = '0;
            if (reg_wr && reg_addr == 2'd0) chg = reg_wdata ^ m_mode;
            if (reg_wr && reg_addr == 2'd1) chg = reg_wdata ^ m_pol;
            nf = m_flag;
            for (int i = 0; i < 4; i++) begin
                bit ev;
                if (m_mode[i]) ev = m_pol[i] ? (s[i] && !p[i]) : (!s[i] && p[i]);
                else           ev = (s[i] == m_pol[i]);
                if (chg[i])    nf[i] = 1'b0;
                else if (ev)   nf[i] = 1'b1;
                else if (reg_wr && reg_addr == 2'd2 && reg_wdata[i]) nf[i] = 1'b0;
            end
            m_flag = nf;
            if (reg_wr && reg_addr == 2'd0) m_mode = reg_wdata;
            if (reg_wr && reg_addr == 2'd1) m_pol  = reg_wdata;
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [3:0] exp_rd;
            case (reg_addr)
                2'd0: exp_rd = m_mode;
                2'd1: exp_rd = m_pol;
                2'd2: exp_rd = m_flag;
                default: exp_rd = '0;
            endcase
            chk(irq == m_flag, {cur_tag, " R11 irq vs model"}, irq, m_flag);
            chk(reg_rdata == exp_rd, {cur_tag, " R3 rdata vs model"}, reg_rdata, exp_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic set_pins(input logic [3:0] v);
        @(posedge clk); #1;
        pin_in = v;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rd(input logic [1:0] a, input logic [3:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        cur_tag = "R1";
        edges(3);
        chk(irq == 4'h0, "R1 irq after reset", irq, 4'h0);
        rd(2'd0, 4'h0, "R1 sense reset");
        rd(2'd1, 4'h0, "R1 polarity reset");
        rd(2'd2, 4'h0, "R1 pending reset");

        // R3 register map
        cur_tag = "R3";
        wr(2'd0, 4'b1010); rd(2'd0, 4'b1010, "R3 sense readback");
        wr(2'd1, 4'b0110); rd(2'd1, 4'b0110, "R3 polarity readback");
        rd(2'd3, 4'h0, "R3 unused address");
        wr(2'd0, 4'hF); wr(2'd1, 4'h0);
        edges(2);
        chk(irq == 4'h0, "R3 no flags after setup", irq, 4'h0);

        // R2 / R4 falling edge, latency
        cur_tag = "R4";
        set_pins(4'b1110);
        edges(1); chk(irq == 4'h0, "R2 not after edge 1", irq, 4'h0);
        edges(1); chk(irq == 4'h0, "R2 not after edge 2", irq, 4'h0);
        edges(1); chk(irq == 4'b0001, "R2 R4 set after edge 3", irq, 4'b0001);
        wr(2'd2, 4'b0001); edges(1);
        set_pins(4'hF); edges(5);
        chk(irq == 4'h0, "R4 rising edge ignored", irq, 4'h0);

        // R5 rising edge
        cur_tag = "R5";
        wr(2'd1, 4'hF);
        set_pins(4'b1101); edges(5);
        chk(irq == 4'h0, "R5 falling edge ignored", irq, 4'h0);
        set_pins(4'hF); edges(3);
        chk(irq == 4'b0010, "R5 rising edge sets", irq, 4'b0010);

        // R7 write-one-to-clear
        cur_tag = "R7";
        wr(2'd2, 4'h0); edges(1);
        chk(irq == 4'b0010, "R7 write zero no effect", irq, 4'b0010);
        set_pins(4'b1011); set_pins(4'hF); edges(4);
        rd(2'd2, 4'b0110, "R7 two flags pending");
        wr(2'd2, 4'b0100); edges(1);
        chk(irq == 4'b0010, "R7 clears only written bit", irq, 4'b0010);
        wr(2'd2, 4'b0010); edges(1);
        chk(irq == 4'h0, "R7 write back clears", irq, 4'h0);

        // R6 level mode
        cur_tag = "R6";
        wr(2'd0, 4'h0); edges(1);
        chk(irq == 4'hF, "R6 active-high level sets", irq, 4'hF);
        set_pins(4'h0); edges(4);
        chk(irq == 4'hF, "R6 flag sticky after level drops", irq, 4'hF);

        // R8 clear blocked while active
        cur_tag = "R8";
        wr(2'd1, 4'h0); edges(1);
        chk(irq == 4'hF, "R8 active-low level sets", irq, 4'hF);
        wr(2'd2, 4'hF); edges(1);
        chk(irq == 4'hF, "R8 clear blocked while active", irq, 4'hF);
        set_pins(4'hF); edges(4);
        wr(2'd2, 4'hF); edges(1);
        chk(irq == 4'h0, "R8 clear after inactive", irq, 4'h0);

        // R9 configuration change clears only changed channels
        cur_tag = "R9";
        wr(2'd0, 4'hF); edges(2);
        set_pins(4'b0110); set_pins(4'hF); edges(4);
        chk(irq == 4'b1001, "R9 two flags set", irq, 4'b1001);
        wr(2'd0, 4'b1110); edges(1);
        chk(irq == 4'b1000, "R9 changed channel cleared", irq, 4'b1000);
        wr(2'd0, 4'hF); wr(2'd2, 4'hF); edges(1);

        // R10 event meets clear write on one edge
        cur_tag = "R10";
        set_pins(4'b0111); edges(3);
        chk(irq == 4'b1000, "R10 first flag", irq, 4'b1000);
        set_pins(4'hF); edges(4);
        set_pins(4'b0111);
        @(posedge clk);
        wr(2'd2, 4'b1000); edges(0);
        chk(irq == 4'b1000, "R10 set wins over clear", irq, 4'b1000);
        wr(2'd2, 4'b1000); edges(1);
        chk(irq == 4'h0, "R10 later clear works", irq, 4'h0);
        set_pins(4'hF);

        cur_tag = "R11";
        edges(5);
        rd(2'd2, irq, "R11 irq equals pending read");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule